// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that counts a slow, free-running watchdog clock and asks for a system reset when software stops clearing it. The timeout comes from a binary divider on that clock. A 3-bit select picks which power-of-two tap ends the count. The same 8-bit control register also holds a 5-bit enable key.

Only two key codes are legal. Their meaning depends on a static configuration input. In the always-on configuration, both legal codes keep the watchdog counting. In the software-controlled configuration, one legal code stops the count and the other starts it.

Any other key value raises the reset request a short, fixed number of watchdog-clock edges later. This applies whether the value arrived by a bus write or by corruption of the stored bits, because legality is decoded from the held register contents on every cycle.

Two sticky cause flags record why a request occurred: one for a bad key and one for a divider timeout. Only a bus write of zero or power-on reset clears them. The bus side runs on the system clock, and the divider runs on the watchdog clock. The system clock must be at least twice as fast as the watchdog clock.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset, the control register reads 0x53: key 01010 in bits 7..3 and select 011 in bits 2..0. Both cause flags read 0 and `rstReq` is low.
- R2: A write with `regSel`=0 stores `wrData` in the control register, and a read with `regSel`=0 returns it unchanged. A read with `regSel`=1 returns the flag register: key-cause flag in bit 0, timeout flag in bit 1, bits 7..2 zero.
- R3: While counting, the divider exponent E is (8+2·sel for sel<4, 11+sel for sel≥4) minus `EXP_TRIM`. `rstReq` rises between 2^E and 2^E+4 watchdog-clock edges after the enabling write.
- R4: With `cfgAlways`=0, key 10101 stops the divider and no timeout request is made, however long the wait. Key 01010 makes the divider count.
- R5: With `cfgAlways`=1, key 10101 and key 01010 both keep the divider counting to a timeout.
- R6: In either configuration, every key other than 10101 and 01010 makes `rstReq` high on the third rising `wdtClk` edge after the write edge. It stays high while the key stays illegal and drops within five edges of a legal key being written.
- R7: A bad-key request sets flag bit 0. The bit stays set after the request ends. Writing 0 to bit 0 clears it, and writing 1 there has no effect.
- R8: A timeout sets flag bit 1, and a bad key never sets it. A timeout does not set bit 0. Writing 0 to bit 1 clears it.
- R9: Pulses on `clrWdt` spaced closer than the timeout keep `rstReq` low. When the pulses stop, a timeout follows within one period.
- R10: A timeout request lasts exactly one watchdog-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | System/bus clock |
| wdtClk | input | 1 | Slow watchdog clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| cfgAlways | input | 1 | Static option: 1 = always counting, 0 = software enabled |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 control, 1 flags |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| clrWdt | input | 1 | One-cycle strobe that restarts the divider |
| rstReq | output | 1 | Reset request (watchdog clock domain) |
| keyFlag | output | 1 | Sticky bad-key cause flag |
| toFlag | output | 1 | Sticky timeout cause flag |

## Verification
The bench builds the block with `EXP_TRIM`=6, so the eight timeouts shrink to 4 through 4096 watchdog cycles. With that setting, every select code can be driven to an actual timeout and its period measured against the exponent formula. All 32 key codes are swept in both configurations. Each illegal code is checked for its three-edge request latency, its held request, its release, and the sticky-flag write rules.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int KEY_W        = 5;
  localparam int SEL_W        = 3;
  localparam int CTRL_W       = KEY_W + SEL_W;
  localparam int MAX_BASE_EXP = 18;

  localparam logic [KEY_W-1:0]  KEY_ON   = 5'b01010;
  localparam logic [KEY_W-1:0]  KEY_OFF  = 5'b10101;
  localparam logic [SEL_W-1:0]  SEL_POR  = 3'b011;
  localparam logic [CTRL_W-1:0] CTRL_POR = {KEY_ON, SEL_POR};

  // Bus-domain decisions handed to the watchdog-clock datapath.
  typedef struct packed {
    logic             keyBad;
    logic             runEn;
    logic [SEL_W-1:0] sel;
    logic             clrTgl;
  } wdtCmd_t;

  // Watchdog-clock events handed back to the bus domain.
  typedef struct packed {
    logic keyReq;
    logic toPulse;
  } wdtEvt_t;

  // Divider exponent for a select code, reduced by a trim for small builds.
  function automatic int tapExp(input int sel, input int trim);
    int base;
    base = (sel < 4) ? (8 + 2 * sel) : (11 + sel);
    return base - trim;
  endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= {STAGES{RST_VAL}};
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              porN,
  input  logic              cfgAlways,
  input  logic              wrEn,
  input  logic              regSel,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              clrWdt,
  input  wdtEvt_t           evt,
  output logic [CTRL_W-1:0] rdData,
  output wdtCmd_t           cmd,
  output logic              keyFlag,
  output logic              toFlag
);

  localparam int KEY_LSB = SEL_W;

  logic [CTRL_W-1:0] ctrlQ, ctrlNext;
  logic [KEY_W-1:0]  keyNext;
  logic              keyBadQ, runQ, clrTglQ;
  logic              keyFlagQ, toFlagQ;
  logic [1:0]        evS, evPrev, evRise;
  logic              flagWr, keyLegalNext;

  function automatic logic keyLegal(input logic [KEY_W-1:0] k);
    return (k == KEY_ON) || (k == KEY_OFF);
  endfunction

  // Decode from the next register value so that the decision bits and the
  // register change on the same bus edge.
  assign ctrlNext     = (wrEn && !regSel) ? wrData : ctrlQ;
  assign keyNext      = ctrlNext[CTRL_W-1:KEY_LSB];
  assign keyLegalNext = keyLegal(keyNext);
  assign flagWr       = wrEn && regSel;

  always_ff @(posedge busClk or negedge porN) begin
    if (!porN) begin
      ctrlQ   <= CTRL_POR;
      keyBadQ <= 1'b0;
      runQ    <= 1'b1;
      clrTglQ <= 1'b0;
    end else begin
      ctrlQ   <= ctrlNext;
      keyBadQ <= !keyLegalNext;
      runQ    <= keyLegalNext && (cfgAlways || (keyNext == KEY_ON));
      clrTglQ <= clrTglQ ^ clrWdt;
    end
  end

  // Events from the watchdog domain, brought in and edge-detected.
  wdt_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) evSyncI (
    .clk (busClk),
    .rstN(porN),
    .d   ({evt.keyReq, evt.toPulse}),
    .q   (evS)
  );

  assign evRise = evS & ~evPrev;

  always_ff @(posedge busClk or negedge porN) begin
    if (!porN) begin
      evPrev   <= 2'b00;
      keyFlagQ <= 1'b0;
      toFlagQ  <= 1'b0;
    end else begin
      evPrev   <= evS;
      keyFlagQ <= evRise[1] | (keyFlagQ & ~(flagWr & ~wrData[0]));
      toFlagQ  <= evRise[0] | (toFlagQ  & ~(flagWr & ~wrData[1]));
    end
  end

  assign cmd.keyBad = keyBadQ;
  assign cmd.runEn  = runQ;
  assign cmd.sel    = ctrlQ[SEL_W-1:0];
  assign cmd.clrTgl = clrTglQ;

  assign rdData  = regSel ? {{(CTRL_W-2){1'b0}}, toFlagQ, keyFlagQ} : ctrlQ;
  assign keyFlag = keyFlagQ;
  assign toFlag  = toFlagQ;

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int EXP_TRIM    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic    wdtClk,
  input  logic    porN,
  input  wdtCmd_t cmd,
  output wdtEvt_t evt,
  output logic    rstReq
);

  localparam int CNT_W    = MAX_BASE_EXP - EXP_TRIM;
  localparam int N_TAPS   = 1 << SEL_W;
  localparam int CMD_W    = $bits(wdtCmd_t);
  localparam logic [CMD_W-1:0] CMD_RST = {1'b0, 1'b1, SEL_POR, 1'b0};

  logic [CMD_W-1:0] cmdSBits;
  wdtCmd_t          cmdS;
  logic [CNT_W-1:0] maskTab [N_TAPS];
  logic [CNT_W-1:0] tapMask, cnt;
  logic             tglPrev, clrHit, hit, toPulseQ, keyStageQ;

  wdt_sync #(.W(CMD_W), .STAGES(SYNC_STAGES), .RST_VAL(CMD_RST)) cmdSyncI (
    .clk (wdtClk),
    .rstN(porN),
    .d   (cmd),
    .q   (cmdSBits)
  );

  assign cmdS = cmdSBits;

  // One terminal-count mask per select code, derived from the exponent rule.
  for (genvar s = 0; s < N_TAPS; s++) begin : gTap
    localparam int E = tapExp(s, EXP_TRIM);
    assign maskTab[s] = {CNT_W{1'b1}} >> (CNT_W - E);
  end

  assign tapMask = maskTab[cmdS.sel];
  assign clrHit  = cmdS.clrTgl ^ tglPrev;
  assign hit     = cmdS.runEn && ((cnt & tapMask) == tapMask);

  always_ff @(posedge wdtClk or negedge porN) begin
    if (!porN) begin
      tglPrev   <= 1'b0;
      keyStageQ <= 1'b0;
      toPulseQ  <= 1'b0;
      cnt       <= '0;
    end else begin
      tglPrev   <= cmdS.clrTgl;
      keyStageQ <= cmdS.keyBad;
      toPulseQ  <= hit && !clrHit;
      if (!cmdS.runEn || clrHit || hit) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
    end
  end

  assign evt.keyReq  = keyStageQ;
  assign evt.toPulse = toPulseQ;
  assign rstReq      = keyStageQ | toPulseQ;

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int EXP_TRIM    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       busClk,
  input  logic       wdtClk,
  input  logic       porN,
  input  logic       cfgAlways,
  input  logic       wrEn,
  input  logic       regSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       clrWdt,
  output logic       rstReq,
  output logic       keyFlag,
  output logic       toFlag
);

  wdtCmd_t cmdBus;
  wdtEvt_t evtBus;

  wdt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrlI (
    .busClk   (busClk),
    .porN     (porN),
    .cfgAlways(cfgAlways),
    .wrEn     (wrEn),
    .regSel   (regSel),
    .wrData   (wrData),
    .clrWdt   (clrWdt),
    .evt      (evtBus),
    .rdData   (rdData),
    .cmd      (cmdBus),
    .keyFlag  (keyFlag),
    .toFlag   (toFlag)
  );

  wdt_core #(.EXP_TRIM(EXP_TRIM), .SYNC_STAGES(SYNC_STAGES)) coreI (
    .wdtClk(wdtClk),
    .porN  (porN),
    .cmd   (cmdBus),
    .evt   (evtBus),
    .rstReq(rstReq)
  );

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic       busClk,
  input logic       wdtClk,
  input logic       porN,
  input logic       wrEn,
  input logic       regSel,
  input logic [7:0] wrData,
  input logic       keyFlag,
  input logic       toFlag,
  input wdtCmd_t    cmd,
  input wdtEvt_t    evt
);

  // R6
  key_delay_chk: assert property (@(posedge wdtClk) disable iff (!porN)
    $rose(evt.keyReq) |-> $past(cmd.keyBad, SYNC_STAGES + 1));

  // R4
  quiet_off_chk: assert property (@(posedge wdtClk) disable iff (!porN)
    $past(!cmd.runEn, SYNC_STAGES + 1) |-> !evt.toPulse);

  // R10
  pulse_width_chk: assert property (@(posedge wdtClk) disable iff (!porN)
    evt.toPulse |=> !evt.toPulse);

  // R7
  key_flag_hold_chk: assert property (@(posedge busClk) disable iff (!porN)
    $fell(keyFlag) |-> $past(wrEn && regSel && !wrData[0]));

  // R8
  to_flag_hold_chk: assert property (@(posedge busClk) disable iff (!porN)
    $fell(toFlag) |-> $past(wrEn && regSel && !wrData[1]));

endmodule

bind wdt_keyed wdt_keyed_chk #(.SYNC_STAGES(SYNC_STAGES)) chkI (
  .busClk (busClk),
  .wdtClk (wdtClk),
  .porN   (porN),
  .wrEn   (wrEn),
  .regSel (regSel),
  .wrData (wrData),
  .keyFlag(keyFlag),
  .toFlag (toFlag),
  .cmd    (cmdBus),
  .evt    (evtBus)
);

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;

  localparam int TRIM = 6;
  localparam logic [4:0] K_ON  = 5'b01010;
  localparam logic [4:0] K_OFF = 5'b10101;

  logic       busClk = 1'b0;
  logic       wdtClk = 1'b0;
  logic       porN = 1'b0;
  logic       cfgAlways = 1'b0;
  logic       wrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       clrWdt = 1'b0;
  logic [7:0] rdData;
  logic       rstReq, keyFlag, toFlag;

  int total = 0;
  int bad   = 0;

  always #4  busClk = ~busClk;   // 125 MHz
  always #16 wdtClk = ~wdtClk;

  wdt_keyed #(.EXP_TRIM(TRIM)) dut_i (
    .busClk(busClk), .wdtClk(wdtClk), .porN(porN), .cfgAlways(cfgAlways),
    .wrEn(wrEn), .regSel(regSel), .wrData(wrData), .rdData(rdData),
    .clrWdt(clrWdt), .rstReq(rstReq), .keyFlag(keyFlag), .toFlag(toFlag)
  );

  function automatic int expOf(input int s);
    return ((s < 4) ? (8 + 2 * s) : (11 + s)) - TRIM;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic busWr(input logic sel, input logic [7:0] d);
    @(negedge busClk);
    wrEn = 1'b1; regSel = sel; wrData = d;
    @(posedge busClk); #1;
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic sel, output logic [7:0] v);
    @(negedge busClk);
    regSel = sel;
    #1 v = rdData;
  endtask

  task automatic clrPulse();
    @(negedge busClk);
    clrWdt = 1'b1;
    @(posedge busClk); #1;
    clrWdt = 1'b0;
  endtask

  task automatic waitWdt(input int n);
    repeat (n) @(posedge wdtClk);
    #1;
  endtask

  // Number of wdtClk edges until rstReq seen high, 0 if never.
  task automatic waitReq(input int maxEdges, output int n);
    n = 0;
    for (int i = 1; i <= maxEdges; i++) begin
      @(posedge wdtClk); #1;
      if (rstReq) begin n = i; break; end
    end
  endtask

  task automatic doReset(input logic always_on);
    logic [7:0] v;
    porN = 1'b0; cfgAlways = always_on;
    repeat (3) @(posedge wdtClk);
    @(negedge busClk); porN = 1'b1;
    busRd(1'b0, v); check("R1 ctrl por", v, 8'h53);
    busRd(1'b1, v); check("R1 flags por", v, 0);
    check("R1 rstReq por", rstReq, 0);
  endtask

  task automatic keySweep(input string mode);
    logic [7:0] v;
    int n;
    busWr(1'b0, {K_ON, 3'b111});
    clrPulse();
    waitWdt(10);
    busWr(1'b1, 8'h00);
    for (int k = 0; k < 32; k++) begin
      logic [4:0] kk;
      int ill;
      kk  = 5'(k);
      ill = (kk != K_ON && kk != K_OFF) ? 1 : 0;
      busWr(1'b0, {kk, 3'b111});
      waitReq(8, n);
      check({"R6 latency ", mode}, n, ill ? 3 : 0);
      busRd(1'b0, v); check("R2 readback", v, {kk, 3'b111});
      if (ill != 0) begin
        waitWdt(3);
        check({"R6 held ", mode}, rstReq, 1);
      end
      busRd(1'b1, v);
      check("R7 key flag set", v[0], ill);
      check("R8 no timeout flag from key", v[1], 0);
      check("R2 flag upper zero", v[7:2], 0);
      busWr(1'b0, {K_ON, 3'b111});
      waitWdt(5);
      check({"R6 release ", mode}, rstReq, 0);
      busWr(1'b1, 8'h01);
      busRd(1'b1, v); check("R7 sticky after release, write 1 no effect", v[0], ill);
      busWr(1'b1, 8'h02);
      busRd(1'b1, v); check("R7 cleared by write 0", v[1:0], 0);
      clrPulse();
    end
  endtask

  initial begin
    #1_400_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, highs;

    // ---- software-enabled configuration ----
    doReset(1'b0);

    // R3 / R10 / R8: every select code reaches its timeout
    for (int s = 0; s < 8; s++) begin
      int e;
      e = expOf(s);
      busWr(1'b0, {K_OFF, 3'(s)});
      waitWdt(6);
      busWr(1'b1, 8'h00);
      busRd(1'b1, v); check("R8 flags cleared", v[1:0], 0);
      busWr(1'b0, {K_ON, 3'(s)});
      waitReq((1 << e) + 10, n);
      checkRange("R3 timeout period", n, 1 << e, (1 << e) + 4);
      @(posedge wdtClk); #1;
      check("R10 one-cycle pulse", rstReq, 0);
      waitWdt(2);
      busRd(1'b1, v); check("R8 timeout flag only", v[1:0], 2);
    end

    // R4: key 10101 stops the divider in software mode
    busWr(1'b0, {K_OFF, 3'b000});
    waitWdt(6);
    highs = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge wdtClk); #1;
      if (rstReq) highs++;
    end
    check("R4 disabled quiet", highs, 0);

    // R9: periodic clears keep the request away
    busWr(1'b0, {K_ON, 3'b010});
    highs = 0;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 30; j++) begin
        @(posedge wdtClk); #1;
        if (rstReq) highs++;
      end
      clrPulse();
    end
    check("R9 cleared stays quiet", highs, 0);
    waitReq(80, n);
    checkRange("R9 timeout after clears stop", n, 30, 70);

    keySweep("soft");

    // ---- always-enabled configuration ----
    doReset(1'b1);
    busWr(1'b0, {K_OFF, 3'b000});
    waitReq(20, n);
    checkRange("R5 10101 still counts", n, 1, 20);
    busWr(1'b0, {K_ON, 3'b001});
    clrPulse();
    waitReq(40, n);
    checkRange("R5 01010 counts", n, 16, 20);

    keySweep("always");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule